// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

This block watches a demodulated infrared receiver line and turns it into run-length samples. The line is first passed through a short synchronizer chain. A programmable sample period, set in microseconds, then divides time into ticks. Each stretch of constant level is measured in ticks. When the level changes, the finished run is written as one byte. The low seven bits of that byte hold the tick count. The top bit marks a space, meaning the input was low; an input that is high is a pulse.

Samples go into a buffer built from two halves of four bytes each. Once a half is full, a status flag switches to the other half and an interrupt is raised, so software can read the finished half while the other one fills. Software uses a small register interface to set the period, turn receiving on and off, choose between saturating and wrapping counts, read the half flag and clear the interrupt. The registers sit at address 0 (control: bit 0 enables receiving, bit 1 enables saturation), address 1 (period), address 2 (status: bit 0 is the half being written, bit 1 is the interrupt), and addresses 8 + 4·h + i (entry i of half h).

Turning receiving off flushes the open half. This is how software ends a trailing stream of spaces: it clears the enable bit and then sets it again.

Top module: `ir_rlc_sampler`

## Requirements
- R1: After reset the control register reads 0, the period reads 50, the status reads 0, irqOut is low and all eight buffer entries read 0.
- R2: Writing a period of 5 to 127 to address 1 loads that value. Writing a value below 5 loads 50. Data bit 7 is ignored.
- R3: A stored sample byte has bit 7 set when the run was low (space) and clear when it was high (pulse). Bits 6:0 hold floor(run clocks / (period · CLKS_PER_US)).
- R4: A run shorter than one sample period is stored with count 1, so that 0 never appears as a real sample.
- R5: When control bit 1 is clear, the count wraps modulo 128. A run of 130 periods is stored as 2.
- R6: When control bit 1 is set, the count saturates at 127.
- R7: The level that is present when receiving is enabled is discarded. Recording begins with the run that follows the first input edge.
- R8: Samples fill entries 0 to 3 of the current half in order. After the fourth sample, status bit 0 toggles and the interrupt (status bit 1 and irqOut) is set.
- R9: Writing address 2 with data bit 1 at 0 clears the interrupt. Writing it with bit 1 at 1 leaves the interrupt set.
- R10: Clearing control bit 0 flushes the current half. The open run is stored (unless it was the discarded first run), the remaining entries of the half are written with 0, and the half is handed over as in R8. If nothing was stored and no run is pending, nothing is handed over.
- R11: While receiving is disabled, input edges write no entry and change no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irIn | input | 1 | Demodulated IR line; high is pulse, low is space |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (4) | Register or buffer address |
| regWrData | input | BYTE_W (8) | Register write data |
| regRdData | output | BYTE_W (8) | Read data for regAddr (combinational) |
| irqOut | output | 1 | Half-ready interrupt |

## Verification
The bench builds the block with CLKS_PER_US set to 1 and all other parameters at their defaults. With a 5 µs period, a tick is then only five clocks long. Runs long enough to wrap at 128 or saturate at 127 therefore fit in a few hundred cycles, and exact tick counts can be predicted from clock counts. Because each half holds four entries, both halves, a full handover and a zero-filled flush can all be reached with about a dozen runs.

// File: rtl/ir_rlc_pkg.sv
package ir_rlc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH
  } rlcState_e;

  typedef struct packed {
    logic runClear;    // restart the tick phase and run counter
    logic latchLevel;  // take the synchronized level as the run level
    logic storeRun;    // write the open run into the buffer
    logic storeZero;   // write an end-of-data zero into the buffer
  } rlcStrobe_t;

  localparam int REG_CTRL     = 0;
  localparam int REG_PERIOD   = 1;
  localparam int REG_STATUS   = 2;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SAT_BIT = 1;
  localparam int STAT_HALF_BIT = 0;
  localparam int STAT_IRQ_BIT  = 1;

endpackage

// File: rtl/ir_rlc_datapath.sv
module ir_rlc_datapath
  import ir_rlc_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int PER_W       = 7,
  parameter int CNT_W       = 7,
  parameter int HALF_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              irIn,
  input  rlcStrobe_t                        strobe,
  input  logic [PER_W-1:0]                  periodUs,
  input  logic                              satEn,
  input  logic [$clog2(HALF_DEPTH):0]       rdEntry,
  output logic [CNT_W:0]                    rdByte,
  output logic                              edgeSeen,
  output logic [$clog2(HALF_DEPTH)-1:0]     wrIdx,
  output logic                              writeHalf,
  output logic                              halfDone
);

  localparam int BYTE_W  = CNT_W + 1;
  localparam int IDX_W   = $clog2(HALF_DEPTH);
  localparam int ENTRY_W = IDX_W + 1;
  localparam int ENTRIES = 2 * HALF_DEPTH;
  localparam int PER_MAX = (1 << PER_W) - 1;
  localparam int TICK_W  = $clog2(PER_MAX * CLKS_PER_US + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // input synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  logic irSync;
  logic levelPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], irIn};
  end
  assign irSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  levelPrev <= 1'b0;
    else if (strobe.latchLevel) levelPrev <= irSync;
  end
  assign edgeSeen = irSync ^ levelPrev;

  // sample-period tick
  logic [TICK_W-1:0] periodClks;
  logic [TICK_W-1:0] phaseCnt;
  logic              tick;

  assign periodClks = TICK_W'(periodUs) * TICK_W'(CLKS_PER_US);
  assign tick       = (phaseCnt >= periodClks - TICK_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (strobe.runClear) phaseCnt <= TICK_W'(1);
    else if (tick)            phaseCnt <= '0;
    else                      phaseCnt <= phaseCnt + TICK_W'(1);
  end

  // run-length counter
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runCnt <= '0;
    else if (strobe.runClear) runCnt <= '0;
    else if (tick) begin
      if (runCnt == CNT_MAX) runCnt <= satEn ? CNT_MAX : '0;
      else                   runCnt <= runCnt + CNT_W'(1);
    end
  end

  // sample formation
  logic [CNT_W-1:0]  sampleCount;
  logic [BYTE_W-1:0] storeByte;
  logic              doStore;

  assign sampleCount = (runCnt == '0) ? CNT_W'(1) : runCnt;
  assign storeByte   = strobe.storeRun ? {~levelPrev, sampleCount} : '0;
  assign doStore     = strobe.storeRun | strobe.storeZero;
  assign halfDone    = doStore && (wrIdx == IDX_W'(HALF_DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx     <= '0;
      writeHalf <= 1'b0;
    end else if (doStore) begin
      if (halfDone) begin
        wrIdx     <= '0;
        writeHalf <= ~writeHalf;
      end else begin
        wrIdx <= wrIdx + IDX_W'(1);
      end
    end
  end

  // ping-pong buffer, one register per entry
  logic [ENTRY_W-1:0] wrEntry;
  logic [BYTE_W-1:0]  entryBus [ENTRIES];

  assign wrEntry = {writeHalf, wrIdx};

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic [BYTE_W-1:0] entryQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     entryQ <= '0;
      else if (doStore && wrEntry == ENTRY_W'(e))    entryQ <= storeByte;
    end
    assign entryBus[e] = entryQ;
  end

  assign rdByte = entryBus[rdEntry];

endmodule

// File: rtl/ir_rlc_ctrl.sv
module ir_rlc_ctrl
  import ir_rlc_pkg::*;
#(
  parameter int PER_W      = 7,
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int HALF_DEPTH = 4,
  parameter int PERIOD_DEF = 50,
  parameter int PERIOD_MIN = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [BYTE_W-1:0]              regWrData,
  input  logic                           edgeSeen,
  input  logic [$clog2(HALF_DEPTH)-1:0]  wrIdx,
  input  logic                           halfDone,
  output rlcStrobe_t                     strobe,
  output logic                           cfgEnable,
  output logic                           cfgSat,
  output logic [PER_W-1:0]               periodUs,
  output logic                           irqFlag
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(REG_PERIOD);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

  logic wrCtrl, wrPeriod, wrStatus;
  logic [PER_W-1:0] perIn;
  logic unusedWrBits;

  assign wrCtrl       = regWrEn && (regAddr == A_CTRL);
  assign wrPeriod     = regWrEn && (regAddr == A_PERIOD);
  assign wrStatus     = regWrEn && (regAddr == A_STATUS);
  assign perIn        = regWrData[PER_W-1:0];
  assign unusedWrBits = ^regWrData;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      cfgSat    <= 1'b0;
      periodUs  <= PER_W'(PERIOD_DEF);
    end else begin
      if (wrCtrl) begin
        cfgEnable <= regWrData[CTRL_EN_BIT];
        cfgSat    <= regWrData[CTRL_SAT_BIT];
      end
      if (wrPeriod)
        periodUs <= (perIn < PER_W'(PERIOD_MIN)) ? PER_W'(PERIOD_DEF) : perIn;
    end
  end

  // interrupt flag: a finished half wins over a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     irqFlag <= 1'b0;
    else if (halfDone)                             irqFlag <= 1'b1;
    else if (wrStatus && !regWrData[STAT_IRQ_BIT]) irqFlag <= 1'b0;
  end

  // sequencing
  rlcState_e state, nextState;
  logic firstRun, nextFirst;
  logic runPending, nextPending;

  always_comb begin
    strobe      = '0;
    nextState   = state;
    nextFirst   = firstRun;
    nextPending = runPending;
    unique case (state)
      ST_IDLE: begin
        if (cfgEnable) begin
          strobe.runClear   = 1'b1;
          strobe.latchLevel = 1'b1;
          nextFirst         = 1'b1;
          nextState         = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!cfgEnable) begin
          nextPending = !firstRun;
          nextState   = ST_FLUSH;
        end else if (edgeSeen) begin
          strobe.runClear   = 1'b1;
          strobe.latchLevel = 1'b1;
          if (firstRun) nextFirst       = 1'b0;
          else          strobe.storeRun = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (runPending) begin
          strobe.storeRun = 1'b1;
          nextPending     = 1'b0;
        end else if (wrIdx != '0) begin
          strobe.storeZero = 1'b1;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      firstRun   <= 1'b1;
      runPending <= 1'b0;
    end else begin
      state      <= nextState;
      firstRun   <= nextFirst;
      runPending <= nextPending;
    end
  end

endmodule

// File: rtl/ir_rlc_sampler.sv
module ir_rlc_sampler
  import ir_rlc_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int PER_W       = 7,
  parameter int CNT_W       = 7,
  parameter int HALF_DEPTH  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PERIOD_DEF  = 50,
  parameter int PERIOD_MIN  = 5,
  parameter int BYTE_W      = CNT_W + 1,
  parameter int ADDR_W      = $clog2(HALF_DEPTH) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              irqOut
);

  localparam int IDX_W   = $clog2(HALF_DEPTH);
  localparam int ENTRY_W = IDX_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(REG_PERIOD);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

  rlcStrobe_t         strobe;
  logic               cfgEnable, cfgSat, irqFlag;
  logic [PER_W-1:0]   periodUs;
  logic               edgeSeen, writeHalf, halfDone;
  logic [IDX_W-1:0]   wrIdx;
  logic [BYTE_W-1:0]  rdByte;
  logic [ENTRY_W-1:0] rdEntry;

  assign rdEntry = regAddr[ENTRY_W-1:0];
  assign irqOut  = irqFlag;

  ir_rlc_ctrl #(
    .PER_W(PER_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .HALF_DEPTH(HALF_DEPTH),
    .PERIOD_DEF(PERIOD_DEF), .PERIOD_MIN(PERIOD_MIN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .edgeSeen(edgeSeen), .wrIdx(wrIdx),
    .halfDone(halfDone), .strobe(strobe), .cfgEnable(cfgEnable),
    .cfgSat(cfgSat), .periodUs(periodUs), .irqFlag(irqFlag)
  );

  ir_rlc_datapath #(
    .CLKS_PER_US(CLKS_PER_US), .PER_W(PER_W), .CNT_W(CNT_W),
    .HALF_DEPTH(HALF_DEPTH), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .irIn(irIn), .strobe(strobe),
    .periodUs(periodUs), .satEn(cfgSat), .rdEntry(rdEntry),
    .rdByte(rdByte), .edgeSeen(edgeSeen), .wrIdx(wrIdx),
    .writeHalf(writeHalf), .halfDone(halfDone)
  );

  // read mux: the upper half of the address space maps the buffer
  always_comb begin
    regRdData = '0;
    if (regAddr[ADDR_W-1]) begin
      regRdData = rdByte;
    end else begin
      case (regAddr)
        A_CTRL: begin
          regRdData[CTRL_EN_BIT]  = cfgEnable;
          regRdData[CTRL_SAT_BIT] = cfgSat;
        end
        A_PERIOD: regRdData[PER_W-1:0] = periodUs;
        A_STATUS: begin
          regRdData[STAT_HALF_BIT] = writeHalf;
          regRdData[STAT_IRQ_BIT]  = irqFlag;
        end
        default: regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/ir_rlc_sampler_checker.sv
module ir_rlc_sampler_checker
  import ir_rlc_pkg::*;
#(
  parameter int PER_W      = 7,
  parameter int ADDR_W     = 4,
  parameter int BYTE_W     = 8,
  parameter int HALF_DEPTH = 4,
  parameter int PERIOD_MIN = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWrEn,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [BYTE_W-1:0]             regWrData,
  input logic                          irqOut,
  input logic [PER_W-1:0]              periodUs,
  input logic                          writeHalf,
  input logic [$clog2(HALF_DEPTH)-1:0] wrIdx,
  input logic                          halfDone
);

  localparam int IDX_W = $clog2(HALF_DEPTH);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

  logic clearWr;
  logic unusedChkBits;
  assign clearWr       = regWrEn && (regAddr == A_STATUS) && !regWrData[STAT_IRQ_BIT];
  assign unusedChkBits = ^regWrData;

  AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    periodUs >= PER_W'(PERIOD_MIN)); // R2

  AST_IRQ_ON_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (writeHalf != $past(writeHalf)) |-> irqOut); // R8

  AST_FLIP_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (writeHalf != $past(writeHalf)) |-> ($past(wrIdx) == IDX_W'(HALF_DEPTH - 1) && wrIdx == '0)); // R8

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !halfDone) |=> !irqOut); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clearWr) |=> irqOut); // R9

endmodule

bind ir_rlc_sampler ir_rlc_sampler_checker #(
  .PER_W(PER_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
  .HALF_DEPTH(HALF_DEPTH), .PERIOD_MIN(PERIOD_MIN)
) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .irqOut(irqOut), .periodUs(periodUs),
  .writeHalf(writeHalf), .wrIdx(wrIdx), .halfDone(halfDone)
);

// File: tb/ir_rlc_sampler_test.sv
module ir_rlc_sampler_test;

  localparam int P = 5;  // clocks per tick with a 5 us period and 1 clock per us
  localparam int NVEC = 8;
  localparam int RUN_LEN [NVEC] = '{3, 7, 1, 12, 2, 5, 20, 4};
  localparam logic [7:0] RUN_EXP [NVEC] =
    '{8'h03, 8'h87, 8'h01, 8'h8C, 8'h02, 8'h85, 8'h14, 8'h84};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irIn = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqOut;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ir_rlc_sampler #(.CLKS_PER_US(1)) uut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic checkReg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    hold(4);
    rstN = 1'b1;
    hold(2);

    // R1 reset state
    checkReg("R1 ctrl", 4'd0, 8'h00);
    checkReg("R1 period", 4'd1, 8'd50);
    checkReg("R1 status", 4'd2, 8'h00);
    check("R1 irqOut", {7'b0, irqOut}, 8'h00);
    for (int i = 0; i < 8; i++) checkReg("R1 entry", 4'(8 + i), 8'h00);

    // R2 period loading and clamping
    regWrite(4'd1, 8'd3);
    checkReg("R2 below min", 4'd1, 8'd50);
    regWrite(4'd1, 8'h85);
    checkReg("R2 bit7 ignored", 4'd1, 8'd5);
    regWrite(4'd1, 8'd127);
    checkReg("R2 max", 4'd1, 8'd127);
    regWrite(4'd1, 8'd5);

    // vector table: alternate pulse/space runs, first edge discards idle (R7)
    regWrite(4'd0, 8'h01);
    hold(5);
    for (int v = 0; v < NVEC; v++) begin
      irIn = (v % 2 == 0);
      hold(RUN_LEN[v] * P);
    end
    irIn = 1'b1;  // closes the last run, opens a 130-period pulse
    hold(10);
    for (int i = 0; i < NVEC; i++) checkReg("R3 R7 R8 vector entry", 4'(8 + i), RUN_EXP[i]);
    checkReg("R8 status after two halves", 4'd2, 8'h02);
    check("R8 irqOut", {7'b0, irqOut}, 8'h01);
    regWrite(4'd2, 8'h00);
    checkReg("R9 irq cleared", 4'd2, 8'h00);
    hold(650 - 11);

    // R5 wrap, R6 saturation, R4 short run
    irIn = 1'b0;
    regWrite(4'd0, 8'h03);
    hold(649);
    irIn = 1'b1;
    hold(2);
    irIn = 1'b0;
    hold(700);
    regWrite(4'd0, 8'h02);  // disable: flush stores saturated space (R10)
    hold(10);
    checkReg("R5 wrap", 4'd8, 8'h02);
    checkReg("R6 saturate", 4'd9, 8'hFF);
    checkReg("R4 short run", 4'd10, 8'h01);
    checkReg("R10 flushed run", 4'd11, 8'hFF);
    checkReg("R8 status half1 irq", 4'd2, 8'h03);

    // R9 keep / clear
    regWrite(4'd2, 8'h02);
    checkReg("R9 bit1 set keeps irq", 4'd2, 8'h03);
    regWrite(4'd2, 8'h00);
    checkReg("R9 clear", 4'd2, 8'h01);
    check("R9 irqOut low", {7'b0, irqOut}, 8'h00);

    // R10 zero fill of a partial half
    regWrite(4'd0, 8'h03);
    hold(5);
    irIn = 1'b1;
    hold(50);
    irIn = 1'b0;
    hold(700);
    regWrite(4'd0, 8'h02);
    hold(10);
    checkReg("R7 R3 first sample", 4'd12, 8'h0A);
    checkReg("R10 flushed run", 4'd13, 8'hFF);
    checkReg("R10 zero fill", 4'd14, 8'h00);
    checkReg("R10 zero fill", 4'd15, 8'h00);
    checkReg("R10 handover", 4'd2, 8'h02);

    // R11 edges while disabled
    for (int t = 0; t < 3; t++) begin
      irIn = ~irIn;
      hold(20);
    end
    hold(5);
    checkReg("R11 status unchanged", 4'd2, 8'h02);
    checkReg("R11 entry unchanged", 4'd8, 8'h02);
    checkReg("R11 entry unchanged", 4'd12, 8'h0A);

    // R10 empty enable/disable hands nothing over
    regWrite(4'd2, 8'h00);
    regWrite(4'd0, 8'h03);
    hold(10);
    regWrite(4'd0, 8'h02);
    hold(10);
    checkReg("R10 empty flush", 4'd2, 8'h00);
    check("R10 empty irqOut", {7'b0, irqOut}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule